// File: doc/BRIEF.md
# Hot-Swap Power Sequencing Controller

This block sequences the turn-on of an external pass switch when a card is plugged into a live supply. Its inputs are digital flags from analog comparators: internal bias valid, supply above the undervoltage point, supply above the overvoltage point, inrush current at its limit, and circuit-breaker trip. A latched-mode select is also an input. A digital ramp counter stands in for the gate voltage. The counter climbs one step per prescaler tick, and it stalls while the current-limit flag is set. When it gets near full scale, the switch is driven fully on and an active-low power-good output is asserted.

Two faults end a start attempt: a breaker trip at any time, or a startup that runs too long. Either fault turns the switch off and starts a cool-down. The cool-down reuses the ramp counter as a triangle timer. The counter sweeps up to a retry level and back to zero, a fixed number of times. After that, a new start is made if the supply is still in its window. In latched mode the sweeps are frozen, so the controller stays off until bias is lost or the block is reset. A supply that leaves its window while running simply sends the controller back to idle, with no cool-down.

All control inputs and status outputs are plain level signals with no handshake. There is no data stream, so nothing here can apply back-pressure.

Top module: `hsw_ctrl`

## Requirements
- R1: While `bias_ok` is low, `gate_lvl` is 0, `gate_full` and `low_pwr` are 0, and `pgood_n` is 1, from the clock after `bias_ok` falls; this also holds during reset.
- R2: From idle, a start begins only when `bias_ok` is 1, `uv_ok` is 1 and `ov_flag` is 0; otherwise `gate_lvl` stays 0.
- R3: A start is entered on the first clock edge that sees the window valid, with the ramp at 0. The ramp, shown on `gate_lvl`, then rises by 1 every `CLK_DIV` clocks. The first step comes `CLK_DIV` clocks after entry.
- R4: On any tick where `ilim_flag` is 1 during a start, the ramp does not rise; it resumes on the next tick with the flag clear. The start timer keeps running while the ramp is stalled.
- R5: The full-on state is entered on the tick where the ramp would reach (2^`RAMP_W`-1)-`FULL_MARGIN`. In that state `pgood_n` is 0, `gate_full` and `low_pwr` are 1, and `gate_lvl` is all ones. `ilim_flag` has no effect there.
- R6: If full-on is not reached by tick number `START_TICKS` of a start, the controller enters cool-down: `gate_lvl` is 0, `pgood_n` is 1 and the ramp restarts from 0.
- R7: `cb_trip` seen in the start or full-on state turns the switch off on the next clock (`gate_lvl` 0, `pgood_n` 1) and begins cool-down.
- R8: In cool-down, `ramp_lvl` climbs 0 to `RETRY_LEVEL` and falls back to 0, one step per tick, `RETRY_SWEEPS` times. A new start is entered `CLK_DIV`·2·`RETRY_LEVEL`·`RETRY_SWEEPS` clocks after cool-down entry; meanwhile `gate_lvl` is 0 and `pgood_n` is 1.
- R9: If the window is invalid when cool-down ends, the controller goes idle and starts again only once the window is valid.
- R10: While `latch_mode` is 1, cool-down makes no progress and `ramp_lvl` holds its value, so the switch stays off. Losing bias ends the cool-down, and the next start then proceeds normally.
- R11: If the window becomes invalid during a start or full-on, the switch is off and `pgood_n` is 1 on the next clock. The controller goes idle with no cool-down, and a valid window restarts it at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bias_ok | input | 1 | Internal bias supply valid |
| uv_ok | input | 1 | Supply above undervoltage point |
| ov_flag | input | 1 | Supply above overvoltage point |
| ilim_flag | input | 1 | Inrush current at its limit |
| cb_trip | input | 1 | Circuit-breaker overcurrent |
| latch_mode | input | 1 | 1 freezes cool-down (latch off after a fault) |
| ramp_lvl | output | RAMP_W | Ramp counter (start ramp or cool-down sweep) |
| gate_lvl | output | RAMP_W | Gate drive level: ramp while starting, all ones when full on, else 0 |
| gate_full | output | 1 | Switch fully on |
| pgood_n | output | 1 | Power good, active low |
| low_pwr | output | 1 | Low-power indication in full-on |

## Verification
A corrupted ramp or sweep register shows up on `gate_lvl` or `ramp_lvl` at the next tick, which is at most `CLK_DIV` clocks later. A bad sweep or start-timer count shows up as a restart or a full-on at the wrong clock. The bench compares those edge counts against closed-form expressions. A wrong control state is visible within one clock, because `gate_lvl` and `pgood_n` are decoded directly from it. A state that fails to leave on a breaker trip or a window loss shows up as `pgood_n` still low one clock after the stimulus.

// File: rtl/hsw_pkg.sv
package hsw_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RAMP = 2'd1,
    ST_FULL = 2'd2,
    ST_COOL = 2'd3
  } hsw_state_e;

  function automatic logic in_window(input logic uv_ok, input logic ov_flag);
    return uv_ok & ~ov_flag;
  endfunction

endpackage

// File: rtl/hsw_tick.sv
module hsw_tick #(
  parameter int CLK_DIV = 10000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  output logic tick
);

  generate
    if (CLK_DIV <= 1) begin : g_every
      logic seen_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seen_q <= 1'b0;
        else        seen_q <= clr;
      end
      assign tick = 1'b1 | seen_q;
    end else begin : g_count
      localparam int CW = $clog2(CLK_DIV);
      localparam logic [CW-1:0] LAST = CW'(CLK_DIV - 1);
      logic [CW-1:0] cnt_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                     cnt_q <= '0;
        else if (clr || cnt_q == LAST)  cnt_q <= '0;
        else                            cnt_q <= cnt_q + 1'b1;
      end
      assign tick = (cnt_q == LAST);
    end
  endgenerate

endmodule

// File: rtl/hsw_seq.sv
module hsw_seq
  import hsw_pkg::*;
#(
  parameter int START_TICKS = 1000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bias_ok,
  input  logic       uv_ok,
  input  logic       ov_flag,
  input  logic       cb_trip,
  input  logic       tick,
  input  logic       reach_full,
  input  logic       cool_done,
  output hsw_state_e state_q,
  output logic       leave
);

  localparam int TW = $clog2(START_TICKS + 1);
  localparam logic [TW-1:0] T_LAST = TW'(START_TICKS - 1);

  logic [TW-1:0] tmr_q;
  hsw_state_e    nxt;
  logic          win;
  logic          timeout;

  always_comb win = in_window(uv_ok, ov_flag);
  always_comb timeout = (state_q == ST_RAMP) && tick && (tmr_q == T_LAST);

  always_comb begin
    nxt = state_q;
    if (!bias_ok) begin
      nxt = ST_IDLE;
    end else begin
      case (state_q)
        ST_IDLE: if (win) nxt = ST_RAMP;
        ST_RAMP: begin
          if (cb_trip)         nxt = ST_COOL;
          else if (!win)       nxt = ST_IDLE;
          else if (reach_full) nxt = ST_FULL;
          else if (timeout)    nxt = ST_COOL;
        end
        ST_FULL: begin
          if (cb_trip)   nxt = ST_COOL;
          else if (!win) nxt = ST_IDLE;
        end
        ST_COOL: if (cool_done) nxt = win ? ST_RAMP : ST_IDLE;
        default: nxt = ST_IDLE;
      endcase
    end
  end

  always_comb leave = (nxt != state_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      tmr_q   <= '0;
    end else begin
      state_q <= nxt;
      if (leave)                              tmr_q <= '0;
      else if (state_q == ST_RAMP && tick)    tmr_q <= tmr_q + 1'b1;
    end
  end

endmodule

// File: rtl/hsw_ramp.sv
module hsw_ramp
  import hsw_pkg::*;
#(
  parameter int RAMP_W       = 9,
  parameter int FULL_AT      = 487,
  parameter int RETRY_LEVEL  = 320,
  parameter int RETRY_SWEEPS = 256
) (
  input  logic              clk,
  input  logic              rst_n,
  input  hsw_state_e        state_q,
  input  logic              leave,
  input  logic              tick,
  input  logic              ilim_flag,
  input  logic              latch_mode,
  output logic [RAMP_W-1:0] ramp_q,
  output logic              reach_full,
  output logic              cool_done
);

  localparam int SW = (RETRY_SWEEPS > 1) ? $clog2(RETRY_SWEEPS) : 1;
  localparam logic [SW-1:0]   SW_LAST   = SW'(RETRY_SWEEPS - 1);
  localparam logic [RAMP_W:0] FULL_MARK = (RAMP_W + 1)'(FULL_AT);
  localparam logic [RAMP_W:0] TOP_MARK  = (RAMP_W + 1)'(RETRY_LEVEL);

  logic [RAMP_W:0] ramp_inc;
  logic            down_q;
  logic [SW-1:0]   sweep_q;
  logic            step_up;
  logic            cool_step;
  logic            at_one;

  always_comb begin
    ramp_inc   = {1'b0, ramp_q} + 1'b1;
    at_one     = (ramp_q == RAMP_W'(1));
    step_up    = (state_q == ST_RAMP) && tick && !ilim_flag;
    reach_full = step_up && (ramp_inc >= FULL_MARK);
    cool_step  = (state_q == ST_COOL) && tick && !latch_mode;
    cool_done  = cool_step && down_q && at_one && (sweep_q == SW_LAST);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ramp_q  <= '0;
      down_q  <= 1'b0;
      sweep_q <= '0;
    end else if (leave) begin
      ramp_q  <= '0;
      down_q  <= 1'b0;
      sweep_q <= '0;
    end else if (step_up) begin
      ramp_q <= ramp_inc[RAMP_W-1:0];
    end else if (cool_step) begin
      if (!down_q) begin
        ramp_q <= ramp_inc[RAMP_W-1:0];
        if (ramp_inc == TOP_MARK) down_q <= 1'b1;
      end else begin
        ramp_q <= ramp_q - 1'b1;
        if (at_one) begin
          down_q  <= 1'b0;
          sweep_q <= sweep_q + 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/hsw_ctrl.sv
module hsw_ctrl
  import hsw_pkg::*;
#(
  parameter int CLK_DIV      = 10000,
  parameter int RAMP_W       = 9,
  parameter int FULL_MARGIN  = 24,
  parameter int START_TICKS  = 1000,
  parameter int RETRY_LEVEL  = 320,
  parameter int RETRY_SWEEPS = 256
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bias_ok,
  input  logic              uv_ok,
  input  logic              ov_flag,
  input  logic              ilim_flag,
  input  logic              cb_trip,
  input  logic              latch_mode,
  output logic [RAMP_W-1:0] ramp_lvl,
  output logic [RAMP_W-1:0] gate_lvl,
  output logic              gate_full,
  output logic              pgood_n,
  output logic              low_pwr
);

  localparam int RAMP_MAX = (1 << RAMP_W) - 1;
  localparam int FULL_AT  = RAMP_MAX - FULL_MARGIN;

  hsw_state_e        state_q;
  logic              leave;
  logic              tick;
  logic              reach_full;
  logic              cool_done;
  logic [RAMP_W-1:0] ramp_q;

  hsw_tick #(.CLK_DIV(CLK_DIV)) u_tick (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (leave),
    .tick  (tick)
  );

  hsw_seq #(.START_TICKS(START_TICKS)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .bias_ok    (bias_ok),
    .uv_ok      (uv_ok),
    .ov_flag    (ov_flag),
    .cb_trip    (cb_trip),
    .tick       (tick),
    .reach_full (reach_full),
    .cool_done  (cool_done),
    .state_q    (state_q),
    .leave      (leave)
  );

  hsw_ramp #(
    .RAMP_W       (RAMP_W),
    .FULL_AT      (FULL_AT),
    .RETRY_LEVEL  (RETRY_LEVEL),
    .RETRY_SWEEPS (RETRY_SWEEPS)
  ) u_ramp (
    .clk        (clk),
    .rst_n      (rst_n),
    .state_q    (state_q),
    .leave      (leave),
    .tick       (tick),
    .ilim_flag  (ilim_flag),
    .latch_mode (latch_mode),
    .ramp_q     (ramp_q),
    .reach_full (reach_full),
    .cool_done  (cool_done)
  );

  always_comb begin
    ramp_lvl  = ramp_q;
    gate_full = (state_q == ST_FULL);
    low_pwr   = (state_q == ST_FULL);
    pgood_n   = (state_q != ST_FULL);
    case (state_q)
      ST_RAMP: gate_lvl = ramp_q;
      ST_FULL: gate_lvl = '1;
      default: gate_lvl = '0;
    endcase
  end

endmodule

// File: rtl/hsw_ctrl_chk.sv
module hsw_ctrl_chk
  import hsw_pkg::*;
#(
  parameter int CLK_DIV     = 10000,
  parameter int RAMP_W      = 9,
  parameter int START_TICKS = 1000,
  parameter int RETRY_LEVEL = 320
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bias_ok,
  input logic              uv_ok,
  input logic              ov_flag,
  input logic              ilim_flag,
  input logic              cb_trip,
  input logic              latch_mode,
  input hsw_state_e        st,
  input logic [RAMP_W-1:0] ramp_lvl,
  input logic [RAMP_W-1:0] gate_lvl,
  input logic              gate_full,
  input logic              pgood_n,
  input logic              low_pwr
);

  localparam int unsigned START_CYC = CLK_DIV * START_TICKS;

  int unsigned ramp_cyc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               ramp_cyc <= 0;
    else if (st == ST_RAMP)   ramp_cyc <= ramp_cyc + 1;
    else                      ramp_cyc <= 0;
  end

  p_bias_off_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !bias_ok |=> (gate_lvl == '0 && pgood_n && !gate_full && !low_pwr));

  p_window_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IDLE && !(uv_ok && !ov_flag)) |=> (gate_lvl == '0 && pgood_n));

  p_stall_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ilim_flag && !gate_full && gate_lvl != '0) |=> (gate_lvl <= $past(gate_lvl)));

  p_pg_full_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !pgood_n |-> (gate_full && low_pwr && gate_lvl == '1));

  p_start_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_RAMP) |-> (ramp_cyc < START_CYC));

  p_cb_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cb_trip |=> (pgood_n && gate_lvl == '0));

  p_cool_peak_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_COOL) |-> (int'(ramp_lvl) <= RETRY_LEVEL && gate_lvl == '0 && pgood_n));

  p_latch_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_COOL && latch_mode && bias_ok) |=> (st == ST_COOL && $stable(ramp_lvl)));

  p_win_exit_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (bias_ok && !cb_trip && (st == ST_RAMP || st == ST_FULL) && !(uv_ok && !ov_flag))
      |=> (st == ST_IDLE && pgood_n));

endmodule

bind hsw_ctrl hsw_ctrl_chk #(
  .CLK_DIV     (CLK_DIV),
  .RAMP_W      (RAMP_W),
  .START_TICKS (START_TICKS),
  .RETRY_LEVEL (RETRY_LEVEL)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bias_ok    (bias_ok),
  .uv_ok      (uv_ok),
  .ov_flag    (ov_flag),
  .ilim_flag  (ilim_flag),
  .cb_trip    (cb_trip),
  .latch_mode (latch_mode),
  .st         (state_q),
  .ramp_lvl   (ramp_lvl),
  .gate_lvl   (gate_lvl),
  .gate_full  (gate_full),
  .pgood_n    (pgood_n),
  .low_pwr    (low_pwr)
);

// File: tb/sim_hsw_ctrl.sv
module sim_hsw_ctrl;

  localparam int DIV      = 4;
  localparam int RW       = 6;
  localparam int MARGIN   = 3;
  localparam int START    = 80;
  localparam int LEVEL    = 8;
  localparam int SWEEPS   = 4;
  localparam int ALL1     = (1 << RW) - 1;
  localparam int FULL_AT  = ALL1 - MARGIN;
  localparam int COOL_CYC = DIV * 2 * LEVEL * SWEEPS;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bias_ok = 1'b0, uv_ok = 1'b0, ov_flag = 1'b0;
  logic ilim_flag = 1'b0, cb_trip = 1'b0, latch_mode = 1'b0;
  logic [RW-1:0] ramp_lvl, gate_lvl;
  logic gate_full, pgood_n, low_pwr;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  hsw_ctrl #(
    .CLK_DIV(DIV), .RAMP_W(RW), .FULL_MARGIN(MARGIN),
    .START_TICKS(START), .RETRY_LEVEL(LEVEL), .RETRY_SWEEPS(SWEEPS)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .bias_ok(bias_ok), .uv_ok(uv_ok), .ov_flag(ov_flag),
    .ilim_flag(ilim_flag), .cb_trip(cb_trip), .latch_mode(latch_mode),
    .ramp_lvl(ramp_lvl), .gate_lvl(gate_lvl), .gate_full(gate_full),
    .pgood_n(pgood_n), .low_pwr(low_pwr)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic go_idle();
    bias_ok = 1'b0; uv_ok = 1'b0; ov_flag = 1'b0;
    ilim_flag = 1'b0; cb_trip = 1'b0;
    step();
    bias_ok = 1'b1;
    step();
  endtask

  // counts edges until gate_lvl (sel=0) or ramp_lvl (sel=1) is nonzero
  task automatic count_until(input int sel, input int lim, output int n, output int bad);
    n = 0; bad = 0;
    do begin
      step();
      n++;
      if (sel == 1 && (gate_lvl != 0 || pgood_n != 1'b1)) bad++;
    end while (((sel == 0) ? gate_lvl : ramp_lvl) == 0 && n < lim);
  endtask

  // start from idle with window valid; ilim held on edges lo..hi
  task automatic ramp_run(input string tag, input int lo, input int hi);
    int exp_r = 0;
    int stalls = 0;
    int n_full = 0;
    uv_ok = 1'b1;
    for (int n = 1; n <= 2000; n++) begin
      bit stall = (n >= lo && n <= hi);
      ilim_flag = stall;
      step();
      if (n > 1 && ((n - 1) % DIV) == 0) begin
        if (stall) stalls++;
        else exp_r++;
      end
      if (exp_r == FULL_AT) begin
        n_full = n;
        break;
      end
      if (gate_lvl != exp_r[RW-1:0] || pgood_n != 1'b1) begin
        chk({tag, " ramp level"}, int'(gate_lvl), exp_r);
        break;
      end
    end
    ilim_flag = 1'b0;
    chk({tag, " R3 edges to full-on"}, n_full, 1 + DIV * (FULL_AT + stalls));
    chk("R5 pgood_n low in full-on", int'(pgood_n), 0);
    chk("R5 gate all ones", int'(gate_lvl), ALL1);
    chk("R5 low_pwr/gate_full", int'({low_pwr, gate_full}), 3);
  endtask

  initial begin
    int n, bad;
    repeat (3) step();
    chk("R1 reset pgood_n", int'(pgood_n), 1);
    chk("R1 reset gate", int'(gate_lvl), 0);
    chk("R1 reset ramp", int'(ramp_lvl), 0);
    chk("R1 reset full/lowpwr", int'({gate_full, low_pwr}), 0);
    rst_n = 1'b1;
    step();

    // R1: no bias, window valid
    uv_ok = 1'b1;
    bad = 0;
    repeat (30) begin step(); if (gate_lvl != 0 || pgood_n != 1'b1) bad++; end
    chk("R1 no bias keeps switch off", bad, 0);

    // R2: window invalid
    bias_ok = 1'b1; uv_ok = 1'b0;
    bad = 0;
    repeat (30) begin step(); if (gate_lvl != 0 || pgood_n != 1'b1) bad++; end
    chk("R2 undervoltage blocks start", bad, 0);
    uv_ok = 1'b1; ov_flag = 1'b1;
    bad = 0;
    repeat (30) begin step(); if (gate_lvl != 0 || pgood_n != 1'b1) bad++; end
    chk("R2 overvoltage blocks start", bad, 0);
    ov_flag = 1'b0;
    ramp_run("R3", 0, -1);

    // R1: bias loss while full on
    bias_ok = 1'b0;
    step();
    chk("R1 bias loss pgood_n", int'(pgood_n), 1);
    chk("R1 bias loss gate", int'(gate_lvl), 0);

    // R4: stall mid-ramp
    go_idle();
    ramp_run("R4", 42, 81);
    ilim_flag = 1'b1;
    bad = 0;
    repeat (20) begin step(); if (pgood_n != 1'b0) bad++; end
    chk("R5 ilim ignored in full-on", bad, 0);
    ilim_flag = 1'b0;

    // R7 + R8: breaker in full-on, then cool-down and restart
    cb_trip = 1'b1;
    step();
    cb_trip = 1'b0;
    chk("R7 trip in full-on pgood_n", int'(pgood_n), 1);
    chk("R7 trip in full-on gate", int'(gate_lvl), 0);
    begin
      int peak = 0, zeros = 0, prev = 0, k = 1;
      bad = 0;
      while (gate_lvl == 0 && k < 1000) begin
        step();
        k++;
        if (int'(ramp_lvl) > peak) peak = int'(ramp_lvl);
        if (prev != 0 && ramp_lvl == 0) zeros++;
        prev = int'(ramp_lvl);
        if (gate_lvl == 0 && pgood_n != 1'b1) bad++;
      end
      chk("R8 sweep peak", peak, LEVEL);
      chk("R8 sweep count", zeros, SWEEPS);
      chk("R8 edges to restart", k, 1 + COOL_CYC + DIV);
      chk("R8 off during cool-down", bad, 0);
    end

    // R7 mid-ramp, then R9 window lost during cool-down
    go_idle();
    uv_ok = 1'b1;
    repeat (41) step();
    chk("R7 pre-trip ramp", int'(gate_lvl), 10);
    cb_trip = 1'b1;
    step();
    cb_trip = 1'b0;
    uv_ok = 1'b0;
    chk("R7 trip mid-ramp gate", int'(gate_lvl), 0);
    bad = 0;
    repeat (COOL_CYC + 40) begin step(); if (gate_lvl != 0 || pgood_n != 1'b1) bad++; end
    chk("R9 stays idle without window", bad, 0);
    uv_ok = 1'b1;
    count_until(0, 1000, n, bad);
    chk("R9 start once window returns", n, 1 + DIV);

    // R6: startup timeout with current limit held
    go_idle();
    uv_ok = 1'b1; ilim_flag = 1'b1;
    count_until(1, 2000, n, bad);
    ilim_flag = 1'b0;
    chk("R6 edges to cool-down sweep", n, 1 + DIV * START + DIV);
    chk("R6 switch off through timeout", bad, 0);

    // R10: latched mode
    go_idle();
    latch_mode = 1'b1;
    ramp_run("R10", 0, -1);
    cb_trip = 1'b1;
    step();
    cb_trip = 1'b0;
    bad = 0;
    repeat (2 * COOL_CYC + 100) begin
      step();
      if (ramp_lvl != 0 || gate_lvl != 0 || pgood_n != 1'b1) bad++;
    end
    chk("R10 latched off frozen", bad, 0);
    bias_ok = 1'b0;
    step();
    bias_ok = 1'b1;
    count_until(0, 1000, n, bad);
    chk("R10 power cycle restarts", n, 1 + DIV);
    latch_mode = 1'b0;

    // R11: window loss in full-on and in ramp
    go_idle();
    ramp_run("R11", 0, -1);
    ov_flag = 1'b1;
    step();
    chk("R11 ov in full-on pgood_n", int'(pgood_n), 1);
    chk("R11 ov in full-on gate", int'(gate_lvl), 0);
    ov_flag = 1'b0;
    count_until(0, 1000, n, bad);
    chk("R11 restart without cool-down", n, 1 + DIV);
    repeat (20) step();
    uv_ok = 1'b0;
    step();
    chk("R11 uv in ramp gate", int'(gate_lvl), 0);
    uv_ok = 1'b1;
    count_until(0, 1000, n, bad);
    chk("R11 ramp restart without cool-down", n, 1 + DIV);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog (R1..all): got 150000 cycles expected fewer");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule